// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block lets a host on an I2C bus read and change a 128-byte configuration register space. It also copies that space to and from a word-wide non-volatile store. The register file and the non-volatile array sit outside the block. The block drives a register-file port with a combinational read path, and a non-volatile port whose read data comes back one clock after the address. SCL and SDA are sampled in the system clock domain. SDA is driven only through an open-drain enable, so the block either pulls the line low or leaves it alone.

A write frame works as follows. The first byte after the target address either selects a register or is a command. A register selection sets an internal pointer. Every later byte in that frame is stored at the pointer, and the pointer then steps forward. Read frames return bytes from the pointer onward. Two command codes start a blocking copy once the frame ends with STOP: one saves the whole register file to the store, the other restores the register file from it. A restore also runs by itself when reset is released. During any copy the block reports busy and ignores the bus. During a restore it also holds a signal that keeps every clock output of the chip switched off.

Top module: `cfgi2c_target`

## Requirements
- R1: The target answers only the 7-bit address 1101010, sent as the upper seven bits of the first byte with the direction in bit 0 (0 = write, 1 = read). A frame that carries any other address gets no acknowledge and changes no register.
- R2: In a write frame, a first data byte below 8'h80 is acknowledged and becomes the register pointer. Each following byte is acknowledged, written to the register the pointer selects, and the pointer then advances by one.
- R3: A read frame returns the register at the pointer, MSB first, then advances the pointer. The target keeps sending bytes while the host acknowledges. A host NACK ends the read, and the pointer stays one past the last byte sent.
- R4: The pointer wraps from 8'h7F to 8'h00 on both write and read.
- R5: A first data byte of 8'h80 or above, other than the two command codes, is not acknowledged and leaves the pointer unchanged.
- R6: First data byte 8'hF0 is the save command. After the STOP that ends its frame, all 128 registers are copied to the store in ascending address order, one byte per clock, over 128 consecutive clocks.
- R7: First data byte 8'hF1 is the restore command. After the STOP, all 128 store locations are copied into the register file. The clock-off output is high throughout every restore and low at all other times.
- R8: While a save or restore runs, the busy output is high and SDA is never driven. A frame whose START falls inside a copy is not acknowledged. After the copy, the address is acknowledged again.
- R9: In the first clock after reset is released, a restore is already running with busy and clock-off high. When it ends, every register holds the content of the store.
- R10: A random read works as a write frame that sets only the pointer, then a repeated START and a read-direction address. The data returned starts at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 7 | Register-file address for reads and writes |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data for rf_addr, available in the same clock |
| nv_we | output | 1 | Non-volatile store write strobe |
| nv_addr | output | 7 | Non-volatile store address |
| nv_wdata | output | 8 | Non-volatile store write data |
| nv_rdata | input | 8 | Non-volatile store read data, valid one clock after nv_addr |
| busy | output | 1 | A save or restore is running |
| clk_force_off | output | 1 | Keep all clock outputs off, high during a restore |

## Verification
The bench builds the block with its default parameters: a 7-bit register pointer, two synchroniser stages and the 1101010 address. These settings place the command codes above the register range and keep a full copy at 128 clocks. That copy is shorter than one bus byte, so a frame has to start right after a command's STOP to land inside the busy window. With these values, the bench also covers the pointer wrap at 8'h7F, a rejected pointer such as 8'h85, and a whole-array comparison after each save and restore, all within a short run.

// File: rtl/cfgi2c_pkg.sv
`timescale 1ns/1ps
// Shared constants and state types for the configuration bus target.
// Assumes a pointer width of at most 7 bits, so the command codes never
// overlap a register address.
package cfgi2c_pkg;
    localparam logic [7:0] CMD_SAVE    = 8'hF0;
    localparam logic [7:0] CMD_RESTORE = 8'hF1;

    typedef enum logic [2:0] {
        PS_IDLE, PS_RX, PS_ACK, PS_TX, PS_TXACK
    } proto_st_t;

    typedef enum logic [1:0] {
        BK_ADDR, BK_PTR, BK_DATA, BK_NONE
    } byte_kind_t;

    typedef enum logic [1:0] {
        CP_IDLE, CP_SAVE, CP_RESTORE
    } copy_mode_t;

    typedef enum logic [1:0] {
        PEND_NONE, PEND_SAVE, PEND_RESTORE
    } pend_t;
endpackage

// File: rtl/cfgi2c_line_sync.sv
`timescale 1ns/1ps
// Brings SCL and SDA into the clock domain through STAGES flops each and
// reports one-clock events for SCL edges and for START/STOP conditions.
// Assumes the bus is much slower than clk; there is no glitch filter.
module cfgi2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] line_in;
    logic [1:0] line_s;
    logic [1:0] line_d;

    assign line_in = {scl_i, sda_i};

    // One synchroniser chain per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_chain
        logic [STAGES-1:0] chain_q;
        // Shift the raw line through the chain; an idle bus is high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_in[g]};
        end
        assign line_s[g] = chain_q[STAGES-1];
    end

    // Keep last clock's synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= 2'b11;
        else        line_d <= line_s;
    end

    assign sda_s     = line_s[0];
    assign scl_rise  = line_s[1] & ~line_d[1];
    assign scl_fall  = ~line_s[1] & line_d[1];
    assign start_det = line_s[1] & line_d[1] & line_d[0] & ~line_s[0];
    assign stop_det  = line_s[1] & line_d[1] & ~line_d[0] & line_s[0];
endmodule

// File: rtl/cfgi2c_copy_engine.sv
`timescale 1ns/1ps
// Moves the whole register file to the store (save) or back (restore),
// one byte per clock. A restore starts by itself when reset is released.
// Assumes a combinational register-file read and a one-clock store read.
module cfgi2c_copy_engine
    import cfgi2c_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_save,
    input  logic              req_restore,
    input  logic [7:0]        rf_rdata,
    input  logic [7:0]        nv_rdata,
    output logic              busy,
    output logic              restoring,
    output logic              c_we,
    output logic [ADDR_W-1:0] c_addr,
    output logic [7:0]        c_wdata,
    output logic              nv_we,
    output logic [ADDR_W-1:0] nv_addr,
    output logic [7:0]        nv_wdata
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] SAVE_LAST    = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] RESTORE_LAST = CNT_W'(DEPTH);

    copy_mode_t       mode;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_m1;

    // Step the copy counter and leave the mode when the last byte is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= CP_RESTORE;
            cnt  <= '0;
        end else begin
            unique case (mode)
                CP_IDLE: begin
                    cnt <= '0;
                    if (req_save)         mode <= CP_SAVE;
                    else if (req_restore) mode <= CP_RESTORE;
                end
                CP_SAVE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == SAVE_LAST) mode <= CP_IDLE;
                end
                CP_RESTORE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == RESTORE_LAST) mode <= CP_IDLE;
                end
                default: mode <= CP_IDLE;
            endcase
        end
    end

    assign cnt_m1 = cnt - 1'b1;

    // Restore writes lag the store reads by one clock; save is in-step.
    always_comb begin
        busy      = (mode != CP_IDLE);
        restoring = (mode == CP_RESTORE);
        nv_we     = (mode == CP_SAVE);
        nv_addr   = cnt[ADDR_W-1:0];
        nv_wdata  = rf_rdata;
        c_we      = restoring && (cnt != '0);
        c_addr    = restoring ? cnt_m1[ADDR_W-1:0] : cnt[ADDR_W-1:0];
        c_wdata   = nv_rdata;
    end
endmodule

// File: rtl/cfgi2c_protocol.sv
`timescale 1ns/1ps
// Bus-side state machine: address match, pointer/command byte, register
// writes, MSB-first reads, acknowledge generation and command hand-off
// at STOP. Frames whose START comes during a copy are ignored.
// Assumes the event inputs come from cfgi2c_line_sync.
module cfgi2c_protocol
    import cfgi2c_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter logic [6:0]  DEV_ADDR = 7'b1101010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [7:0]        rf_rdata,
    output logic              sda_oe,
    output logic              p_we,
    output logic [ADDR_W-1:0] p_waddr,
    output logic [7:0]        p_wdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              req_save,
    output logic              req_restore
);
    proto_st_t  state;
    byte_kind_t kind;
    pend_t      pend;
    logic       rw;
    logic       mack;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;

    // Walk the frame: shift bits in or out, acknowledge, decode bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PS_IDLE;
            kind        <= BK_ADDR;
            pend        <= PEND_NONE;
            rw          <= 1'b0;
            mack        <= 1'b0;
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            ptr         <= '0;
            sda_oe      <= 1'b0;
            p_we        <= 1'b0;
            p_waddr     <= '0;
            p_wdata     <= '0;
            req_save    <= 1'b0;
            req_restore <= 1'b0;
        end else begin
            p_we        <= 1'b0;
            req_save    <= 1'b0;
            req_restore <= 1'b0;
            if (stop_det) begin
                state       <= PS_IDLE;
                sda_oe      <= 1'b0;
                req_save    <= (pend == PEND_SAVE);
                req_restore <= (pend == PEND_RESTORE);
                pend        <= PEND_NONE;
            end else if (start_det) begin
                sda_oe  <= 1'b0;
                pend    <= PEND_NONE;
                kind    <= BK_ADDR;
                bit_cnt <= '0;
                state   <= busy ? PS_IDLE : PS_RX;
            end else begin
                unique case (state)
                    PS_IDLE: ;
                    PS_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall && bit_cnt == 4'd8) begin
                            state  <= PS_ACK;
                            sda_oe <= 1'b1;
                            unique case (kind)
                                BK_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR && !busy) begin
                                        rw   <= rx_sh[0];
                                        kind <= BK_PTR;
                                    end else begin
                                        state  <= PS_IDLE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                BK_PTR: begin
                                    if (rx_sh == CMD_SAVE) begin
                                        pend <= PEND_SAVE;
                                        kind <= BK_NONE;
                                    end else if (rx_sh == CMD_RESTORE) begin
                                        pend <= PEND_RESTORE;
                                        kind <= BK_NONE;
                                    end else if ((rx_sh >> ADDR_W) == 8'd0) begin
                                        ptr  <= rx_sh[ADDR_W-1:0];
                                        kind <= BK_DATA;
                                    end else begin
                                        state  <= PS_IDLE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                                BK_DATA: begin
                                    p_we    <= 1'b1;
                                    p_waddr <= ptr;
                                    p_wdata <= rx_sh;
                                    ptr     <= ptr + 1'b1;
                                end
                                default: begin
                                    state  <= PS_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            endcase
                        end
                    end
                    PS_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                tx_sh  <= rf_rdata;
                                sda_oe <= ~rf_rdata[7];
                                ptr    <= ptr + 1'b1;
                                state  <= PS_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= PS_RX;
                            end
                        end
                    end
                    PS_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= PS_TXACK;
                            end else begin
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                sda_oe  <= ~tx_sh[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    PS_TXACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                bit_cnt <= '0;
                                tx_sh   <= rf_rdata;
                                sda_oe  <= ~rf_rdata[7];
                                ptr     <= ptr + 1'b1;
                                state   <= PS_TX;
                            end else begin
                                state <= PS_IDLE;
                            end
                        end
                    end
                    default: state <= PS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgi2c_target.sv
`timescale 1ns/1ps
// Top of the configuration bus target: line synchroniser, bus protocol
// engine and save/restore copy engine. The copy engine owns the register
// port while busy; otherwise the protocol engine does.
// Assumes an external register file with combinational read and an
// external store with one-clock read latency.
module cfgi2c_target #(
    parameter int         ADDR_W      = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1101010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [7:0]        rf_wdata,
    input  logic [7:0]        rf_rdata,
    output logic              nv_we,
    output logic [ADDR_W-1:0] nv_addr,
    output logic [7:0]        nv_wdata,
    input  logic [7:0]        nv_rdata,
    output logic              busy,
    output logic              clk_force_off
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              p_we, req_save, req_restore, c_we;
    logic [ADDR_W-1:0] p_waddr, ptr, c_addr;
    logic [7:0]        p_wdata, c_wdata;

    cfgi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfgi2c_protocol #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .busy(busy), .rf_rdata(rf_rdata), .sda_oe(sda_oe), .p_we(p_we),
        .p_waddr(p_waddr), .p_wdata(p_wdata), .ptr(ptr),
        .req_save(req_save), .req_restore(req_restore)
    );

    cfgi2c_copy_engine #(.ADDR_W(ADDR_W)) u_copy (
        .clk(clk), .rst_n(rst_n), .req_save(req_save),
        .req_restore(req_restore), .rf_rdata(rf_rdata),
        .nv_rdata(nv_rdata), .busy(busy), .restoring(clk_force_off),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .nv_we(nv_we),
        .nv_addr(nv_addr), .nv_wdata(nv_wdata)
    );

    // Hand the register port to whichever engine currently owns it.
    always_comb begin
        if (busy) begin
            rf_we    = c_we;
            rf_addr  = c_addr;
            rf_wdata = c_wdata;
        end else begin
            rf_we    = p_we;
            rf_addr  = p_we ? p_waddr : ptr;
            rf_wdata = p_wdata;
        end
    end
endmodule

// File: rtl/cfgi2c_target_chk.sv
`timescale 1ns/1ps
// Property checker for cfgi2c_target, attached by bind below.
module cfgi2c_target_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              rf_we,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              nv_we,
    input logic [ADDR_W-1:0] nv_addr,
    input logic              busy,
    input logic              clk_force_off
);
    logic fresh_q;

    // Marks the first clock after reset release.
    always_ff @(posedge clk) begin
        fresh_q <= !rst_n;
    end

    // Restore must already be under way right after reset.
    always @(posedge clk) begin
        if (rst_n && fresh_q)
            p_powerup_restore_r9: assert (busy && clk_force_off);
    end

    p_force_off_only_in_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_force_off |-> busy);

    p_save_keeps_clocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> (busy && !clk_force_off));

    p_save_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_we && $past(nv_we)) |-> (nv_addr == $past(nv_addr) + 1'b1));

    p_restore_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && clk_force_off && $past(rf_we && clk_force_off))
            |-> (rf_addr == $past(rf_addr) + 1'b1));

    p_silent_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    p_drive_while_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind cfgi2c_target cfgi2c_target_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cfgi2c_target_bench.sv
`timescale 1ns/1ps
module cfgi2c_target_bench;
    localparam int AW = 7;
    localparam int DEPTH = 1 << AW;
    localparam int Q = 10;
    localparam logic [7:0] ADR_W = 8'hD4;
    localparam logic [7:0] ADR_R = 8'hD5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, rf_we, nv_we, busy, clk_force_off;
    logic [AW-1:0] rf_addr, nv_addr;
    logic [7:0] rf_wdata, rf_rdata, nv_wdata, nv_rdata;
    logic [7:0] rf [DEPTH];
    logic [7:0] nv [DEPTH];

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nv_we_cnt = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfgi2c_target u_cfgi2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .rf_we(rf_we), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .nv_we(nv_we),
        .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata),
        .busy(busy), .clk_force_off(clk_force_off)
    );

    // Register file and store models.
    assign rf_rdata = rf[rf_addr];
    always @(posedge clk) begin
        if (rf_we) rf[rf_addr] <= rf_wdata;
        if (nv_we) nv[nv_addr] <= nv_wdata;
        nv_rdata <= nv[nv_addr];
        if (nv_we) nv_we_cnt <= nv_we_cnt + 1;
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            report();
        end
    end

    // Monitor: compare each received read byte with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(g == e, t, g, e);
                end else begin
                    check(1'b0, "unexpected read byte", g, 0);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_bit(logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(logic last);
        logic [7:0] d;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            d[i] = b;
        end
        wr_bit(last);
        got_q.push_back(d);
    endtask

    task automatic expect_rd(logic [7:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) tick(1);
    endtask

    function automatic int rf_nv_mismatch();
        int m = 0;
        for (int i = 0; i < DEPTH; i++) if (rf[i] !== nv[i]) m++;
        return m;
    endfunction

    initial begin
        logic ack;
        for (int i = 0; i < DEPTH; i++) begin
            nv[i] = pat(i);
            rf[i] = 8'h00;
        end
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R9: restore running from the first clock after reset
        check(busy && clk_force_off, "R9 power-up restore active", {busy, clk_force_off}, 3);
        wait_idle();
        tick(2);
        check(rf_nv_mismatch() == 0, "R9 registers loaded from store", rf_nv_mismatch(), 0);
        check(!clk_force_off && !busy, "R7 clock-off released", {busy, clk_force_off}, 0);

        // R1: foreign address ignored
        i2c_start();
        wr_byte({7'h55, 1'b0}, ack);
        check(!ack, "R1 foreign address not acknowledged", ack, 0);
        wr_byte(8'h10, ack);
        wr_byte(8'hAA, ack);
        i2c_stop();
        check(rf[8'h10] == pat(16), "R1 foreign frame writes nothing", rf[8'h10], pat(16));

        // R2: pointer then burst write
        i2c_start();
        wr_byte(ADR_W, ack);
        check(ack, "R1 own address acknowledged", ack, 1);
        wr_byte(8'h10, ack);
        check(ack, "R2 pointer acknowledged", ack, 1);
        wr_byte(8'h11, ack);
        wr_byte(8'h22, ack);
        wr_byte(8'h33, ack);
        check(ack, "R2 data acknowledged", ack, 1);
        i2c_stop();
        check(rf[8'h10] == 8'h11 && rf[8'h11] == 8'h22 && rf[8'h12] == 8'h33,
              "R2 burst write", {rf[8'h10], rf[8'h11], rf[8'h12]}, 24'h112233);

        // R10 / R3: random read via repeated start, sequential with NACK end
        i2c_start();
        wr_byte(ADR_W, ack);
        wr_byte(8'h10, ack);
        i2c_start();
        wr_byte(ADR_R, ack);
        check(ack, "R10 read address after repeated start", ack, 1);
        expect_rd(8'h11, "R10 first byte at pointer");
        expect_rd(8'h22, "R3 sequential byte 2");
        expect_rd(8'h33, "R3 sequential byte 3");
        rd_byte(1'b0);
        rd_byte(1'b0);
        rd_byte(1'b1);
        i2c_stop();
        tick(2);
        check(!sda_oe, "R3 NACK releases SDA", sda_oe, 0);

        // R3: pointer continues after the NACKed read
        i2c_start();
        wr_byte(ADR_R, ack);
        expect_rd(pat(8'h13), "R3 pointer continues after NACK");
        rd_byte(1'b1);
        i2c_stop();

        // R4: wrap at the top of the space
        i2c_start();
        wr_byte(ADR_W, ack);
        wr_byte(8'h7F, ack);
        wr_byte(8'hA5, ack);
        wr_byte(8'h5A, ack);
        i2c_stop();
        check(rf[8'h7F] == 8'hA5 && rf[0] == 8'h5A, "R4 pointer wrap",
              {rf[8'h7F], rf[0]}, 16'hA55A);

        // R5: out-of-range pointer rejected, pointer kept (now 8'h01)
        i2c_start();
        wr_byte(ADR_W, ack);
        wr_byte(8'h85, ack);
        check(!ack, "R5 out-of-range pointer not acknowledged", ack, 0);
        i2c_stop();
        i2c_start();
        wr_byte(ADR_R, ack);
        expect_rd(pat(1), "R5 pointer unchanged by rejected byte");
        rd_byte(1'b1);
        i2c_stop();

        // R6 / R8: save, then a frame that starts during the copy
        nv_we_cnt = 0;
        i2c_start();
        wr_byte(ADR_W, ack);
        wr_byte(8'hF0, ack);
        check(ack, "R6 save command acknowledged", ack, 1);
        i2c_stop();
        i2c_start();
        check(busy && !clk_force_off, "R6 save busy without clock-off",
              {busy, clk_force_off}, 2);
        wr_byte(ADR_W, ack);
        check(!ack, "R8 address ignored during copy", ack, 0);
        i2c_stop();
        wait_idle();
        tick(2);
        check(nv_we_cnt == DEPTH, "R6 save length", nv_we_cnt, DEPTH);
        check(rf_nv_mismatch() == 0, "R6 store matches registers", rf_nv_mismatch(), 0);
        i2c_start();
        wr_byte(ADR_W, ack);
        check(ack, "R8 address acknowledged after copy", ack, 1);
        i2c_stop();

        // R7: change a register, then restore the saved value
        i2c_start();
        wr_byte(ADR_W, ack);
        wr_byte(8'h20, ack);
        wr_byte(8'hEE, ack);
        i2c_stop();
        check(rf[8'h20] == 8'hEE, "R2 write before restore", rf[8'h20], 8'hEE);
        i2c_start();
        wr_byte(ADR_W, ack);
        wr_byte(8'hF1, ack);
        check(ack, "R7 restore command acknowledged", ack, 1);
        i2c_stop();
        tick(10);
        check(busy && clk_force_off, "R7 clock-off during restore", {busy, clk_force_off}, 3);
        wait_idle();
        tick(2);
        check(rf[8'h20] == pat(8'h20), "R7 register restored", rf[8'h20], pat(8'h20));
        check(rf_nv_mismatch() == 0, "R7 full restore", rf_nv_mismatch(), 0);
        check(!clk_force_off, "R7 clock-off released after restore", clk_force_off, 0);

        tick(10);
        check(exp_q.size() == 0, "R3 all expected reads seen", exp_q.size(), 0);
        done = 1;
        report();
    end
endmodule